// File: doc/BRIEF.md
# Burst Read WAIT Generator

This block produces the WAIT signal and a per-word data strobe for the read side of a synchronous burst NOR flash. A burst begins when the burst-start input is high on a rising clock edge while the chip is enabled. That edge latches the starting word address. After a configurable number of clock edges, one word is presented on every edge. The address steps linearly. It either wraps inside an aligned group of 4, 8 or 16 words, or runs straight across the 16-word wordline boundaries. When it runs straight, the first wordline crossing can insert a number of stall cycles. That number depends on the starting offset and is bounded by the latency.

WAIT leaves the block as a value plus an output enable, so the pad can be floated. The asserted level is set by a polarity bit. A delay bit picks whether WAIT lifts in the same cycle as valid data or one cycle before it. The data strobe `dvalid` has no ready partner. A flash burst cannot be held back, so every cycle with `dvalid` high carries a new word that the consumer must take. The only way to pause output is to raise the output-enable pin. The burst's internal progress keeps advancing while that pin is high.

Top module: `burst_wait_gen`

## Requirements
- R1: `wait_oe` is low whenever `rst_n` is low, `ce_n` is high, `oe_n` is high, or `we_n` is low (write cycle). Otherwise it is high.
- R2: In an asynchronous read (`sync_en`=0, `ce_n`=0, `oe_n`=0, `we_n`=1), WAIT is driven at its deasserted level, and `start_i` starts no burst.
- R3: With `wait_pol`=1, the asserted WAIT level is 1. With `wait_pol`=0, the asserted level is 0 and the deasserted level is 1.
- R4: For a latency count N, the first `dvalid` appears N rising edges after the latch edge, and WAIT is asserted while the burst waits for it.
- R5: With `wait_early`=0, WAIT is deasserted in exactly the burst cycles that carry data. With `wait_early`=1, WAIT in each burst cycle shows whether the following cycle will lack data, so WAIT lifts one cycle before data.
- R6: Without wrap (`wrap_en`=0, or `burst_len`=3 meaning continuous), `data_addr` increases by one per data word, modulo 2^ADDR_W.
- R7: With `wrap_en`=1 and `burst_len` 0, 1 or 2 (groups of 4, 8 or 16 words), only the low address bits count, modulo the group size, and no stall cycles occur.
- R8: Without wrap, when the address steps from wordline offset 15 to the next wordline for the first time in a burst, min(start offset, N-2) stall cycles are inserted. During them `dvalid` is 0 and WAIT is asserted. Later crossings in the same burst insert none.
- R9: A latency count outside 3..16 raises `cfg_bad`, and a `start_i` given while `cfg_bad` is high is ignored.
- R10: `dvalid` is 0 while `ce_n` or `oe_n` is high, and a high `ce_n` on a clock edge ends the burst.
- R11: After reset, `dvalid` is 0 and `wait_oe` is 0 until the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low device reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| start_i | input | 1 | Burst start, sampled on a rising edge (latch edge) |
| start_addr | input | ADDR_W | Starting word address |
| sync_en | input | 1 | 1: synchronous burst reads, 0: asynchronous reads |
| lat_cnt | input | LAT_W | Latency count N in clock edges |
| wait_pol | input | 1 | Asserted WAIT level |
| wait_early | input | 1 | 1: WAIT lifts one cycle before data |
| wrap_en | input | 1 | Wrap inside the aligned group |
| burst_len | input | 2 | 0: 4 words, 1: 8 words, 2: 16 words, 3: continuous |
| wait_o | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT output enable (0 = high impedance) |
| dvalid | output | 1 | A data word is valid this cycle |
| data_addr | output | ADDR_W | Address of the word currently presented |
| cfg_bad | output | 1 | Latency count unsupported |

## Verification
The assertions assume that `lat_cnt`, `wait_pol`, `wait_early`, `wrap_en`, `burst_len` and `sync_en` stay unchanged from the latch edge until the burst ends. The stall bound and the no-stall-when-wrapping checks read these inputs live. The stimulus changes configuration only on the same edge as a start, while the block is idle. Between bursts it raises `ce_n` for a full cycle, so each random or directed burst begins from the idle state.

// File: rtl/bwait_pkg.sv
package bwait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAT   = 2'd1,
    ST_DATA  = 2'd2,
    ST_STALL = 2'd3
  } bst_e;
endpackage

// File: rtl/bwait_cfg.sv
// Latency range check and the stall count applied at the first wordline crossing.
module bwait_cfg #(
  parameter int LAT_W   = 5,
  parameter int OFF_W   = 4,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 16
) (
  input  logic [LAT_W-1:0] lat_cnt,
  input  logic [OFF_W-1:0] start_off,
  output logic             lat_ok,
  output logic [LAT_W-1:0] stall_amt
);
  logic [LAT_W-1:0] limit;
  logic [LAT_W-1:0] off_x;

  always_comb begin
    lat_ok = (lat_cnt >= LAT_W'(LAT_MIN)) && (lat_cnt <= LAT_W'(LAT_MAX));
    limit  = lat_cnt - LAT_W'(2);
    off_x  = LAT_W'(start_off);
    stall_amt = (off_x < limit) ? off_x : limit;
  end
endmodule

// File: rtl/bwait_addr.sv
// Next word address: linear, or wrapping inside an aligned group of 4/8/16.
module bwait_addr #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              wrap_en,
  input  logic [1:0]        blen,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap_act
);
  logic [OFF_W-1:0]  grp_mask;
  logic [ADDR_W-1:0] ext_mask;
  logic [ADDR_W-1:0] inc;

  always_comb begin
    wrap_act = wrap_en && (blen != 2'd3);
    grp_mask = OFF_W'((4 << blen) - 1);
    ext_mask = {{(ADDR_W-OFF_W){1'b0}}, grp_mask};
    inc      = cur + ADDR_W'(1);
    nxt      = wrap_act ? ((cur & ~ext_mask) | (inc & ext_mask)) : inc;
  end
endmodule

// File: rtl/bwait_fsm.sv
// Burst sequencer: latency, data, wordline stall; produces the raw WAIT need.
module bwait_fsm
  import bwait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LAT_W  = 5,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              sync_en,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              lat_ok,
  input  logic [LAT_W-1:0]  lat_cnt,
  input  logic [LAT_W-1:0]  stall_amt,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              wrap_act,
  input  logic              wait_early,
  output bst_e              st,
  output logic [ADDR_W-1:0] addr,
  output logic              wait_need
);
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] stall_q;
  logic             crossed;
  logic             at_end;

  assign at_end = (st == ST_DATA) && !wrap_act && !crossed &&
                  (addr[OFF_W-1:0] == {OFF_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      addr    <= '0;
      stall_q <= '0;
      crossed <= 1'b0;
    end else if (ce_n) begin
      st <= ST_IDLE;
    end else if (start_i && sync_en && lat_ok) begin
      st      <= ST_LAT;
      cnt     <= lat_cnt - LAT_W'(1);
      addr    <= start_addr;
      stall_q <= stall_amt;
      crossed <= 1'b0;
    end else begin
      unique case (st)
        ST_LAT: begin
          if (cnt == '0) st <= ST_DATA;
          else           cnt <= cnt - LAT_W'(1);
        end
        ST_DATA: begin
          addr <= nxt_addr;
          if (at_end) begin
            crossed <= 1'b1;
            if (stall_q != '0) begin
              st  <= ST_STALL;
              cnt <= stall_q - LAT_W'(1);
            end
          end
        end
        ST_STALL: begin
          if (cnt == '0) st <= ST_DATA;
          else           cnt <= cnt - LAT_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (wait_early) begin
      wait_need = ((st == ST_LAT || st == ST_STALL) && cnt != '0) ||
                  (at_end && stall_q != '0);
    end else begin
      wait_need = (st == ST_LAT) || (st == ST_STALL);
    end
  end
endmodule

// File: rtl/bwait_pin.sv
// WAIT pad drive: enable by bus cycle type, level by polarity.
module bwait_pin (
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic sync_en,
  input  logic wait_need,
  input  logic wait_pol,
  output logic wait_o,
  output logic wait_oe
);
  logic act;
  always_comb begin
    wait_oe = rst_n && !ce_n && !oe_n && we_n;
    act     = sync_en && wait_need;
    wait_o  = wait_pol ? act : !act;
  end
endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
  import bwait_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LAT_W    = 5,
  parameter int WL_WORDS = 16,
  parameter int LAT_MIN  = 3,
  parameter int LAT_MAX  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              sync_en,
  input  logic [LAT_W-1:0]  lat_cnt,
  input  logic              wait_pol,
  input  logic              wait_early,
  input  logic              wrap_en,
  input  logic [1:0]        burst_len,
  output logic              wait_o,
  output logic              wait_oe,
  output logic              dvalid,
  output logic [ADDR_W-1:0] data_addr,
  output logic              cfg_bad
);
  localparam int OFF_W = $clog2(WL_WORDS);

  logic              lat_ok;
  logic [LAT_W-1:0]  stall_amt;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic              wrap_act;
  logic              wait_need;
  bst_e              st;

  bwait_cfg #(.LAT_W(LAT_W), .OFF_W(OFF_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_cfg (
    .lat_cnt(lat_cnt), .start_off(start_addr[OFF_W-1:0]),
    .lat_ok(lat_ok), .stall_amt(stall_amt)
  );

  bwait_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .cur(addr), .wrap_en(wrap_en), .blen(burst_len),
    .nxt(nxt_addr), .wrap_act(wrap_act)
  );

  bwait_fsm #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sync_en(sync_en),
    .start_i(start_i), .start_addr(start_addr), .lat_ok(lat_ok),
    .lat_cnt(lat_cnt), .stall_amt(stall_amt), .nxt_addr(nxt_addr),
    .wrap_act(wrap_act), .wait_early(wait_early),
    .st(st), .addr(addr), .wait_need(wait_need)
  );

  bwait_pin u_pin (
    .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .sync_en(sync_en), .wait_need(wait_need), .wait_pol(wait_pol),
    .wait_o(wait_o), .wait_oe(wait_oe)
  );

  assign dvalid    = (st == ST_DATA) && !ce_n && !oe_n;
  assign data_addr = addr;
  assign cfg_bad   = !lat_ok;
endmodule

// File: rtl/bwait_chk.sv
module bwait_chk
  import bwait_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LAT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              sync_en,
  input logic              start_i,
  input logic [LAT_W-1:0]  lat_cnt,
  input logic              wait_pol,
  input logic              wait_early,
  input logic              wrap_en,
  input logic [1:0]        burst_len,
  input logic              wait_o,
  input logic              wait_oe,
  input logic              dvalid,
  input logic [ADDR_W-1:0] data_addr,
  input logic              cfg_bad,
  input bst_e              st
);
  logic [7:0] stall_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               stall_run <= '0;
    else if (st == ST_STALL)  stall_run <= stall_run + 8'd1;
    else                      stall_run <= '0;
  end

  assert_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> !wait_oe);

  assert_async_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && !sync_en) |-> (wait_oe && (wait_o == !wait_pol)));

  assert_latency_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAT && sync_en && !wait_early) |-> (wait_o == wait_pol));

  assert_lift_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && sync_en && !wait_early) |-> (wait_o == !wait_pol));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && $past(dvalid) && !$past(start_i) && !(wrap_en && burst_len != 2'd3))
      |-> (data_addr == $past(data_addr) + ADDR_W'(1)));

  assert_wrap_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && burst_len != 2'd3) |-> (st != ST_STALL));

  assert_stall_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STALL) |-> (32'(stall_run) + 1 <= 32'(lat_cnt) - 2));

  assert_bad_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_i && cfg_bad) |=> (st == ST_IDLE));
endmodule

bind burst_wait_gen bwait_chk #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .sync_en(sync_en), .start_i(start_i), .lat_cnt(lat_cnt),
  .wait_pol(wait_pol), .wait_early(wait_early), .wrap_en(wrap_en),
  .burst_len(burst_len), .wait_o(wait_o), .wait_oe(wait_oe),
  .dvalid(dvalid), .data_addr(data_addr), .cfg_bad(cfg_bad), .st(st)
);

// File: tb/burst_wait_gen_test.sv
`timescale 1ns/1ps
module burst_wait_gen_test;
  localparam int ADDR_W = 16;
  localparam int LAT_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              sync_en = 1'b1;
  logic [LAT_W-1:0]  lat_cnt = 5'd4;
  logic              wait_pol = 1'b0, wait_early = 1'b0, wrap_en = 1'b0;
  logic [1:0]        burst_len = 2'd3;
  logic              wait_o, wait_oe, dvalid, cfg_bad;
  logic [ADDR_W-1:0] data_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_wait_gen uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .start_i(start_i), .start_addr(start_addr), .sync_en(sync_en),
    .lat_cnt(lat_cnt), .wait_pol(wait_pol), .wait_early(wait_early),
    .wrap_en(wrap_en), .burst_len(burst_len), .wait_o(wait_o),
    .wait_oe(wait_oe), .dvalid(dvalid), .data_addr(data_addr), .cfg_bad(cfg_bad)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 0 = latency, 1 = data, 2 = stall, at k edges after the latch edge
  function automatic int st_at(int k, int n, int m, int s);
    int d;
    if (k < n) return 0;
    d = k - n;
    if (s > 0 && d >= m && d < m + s) return 2;
    return 1;
  endfunction

  function automatic int exp_addr(int a, int j, bit wact, int blen);
    int mask;
    mask = (4 << blen) - 1;
    if (wact) return (a & ~mask & 16'hFFFF) | ((a + j) & mask);
    return (a + j) & 16'hFFFF;
  endfunction

  task automatic burst(input int n, input int a, input bit wr, input int bl,
                       input bit pol, input bit early, input int ncyc, input string req);
    bit wact;
    int off, s, m, es, ns, j, d;
    bit act;
    wact = wr && (bl != 3);
    off  = a & 15;
    s    = wact ? 0 : ((off < n - 2) ? off : n - 2);
    m    = 16 - off;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; sync_en = 1'b1;
    lat_cnt = LAT_W'(n); wrap_en = wr; burst_len = 2'(bl);
    wait_pol = pol; wait_early = early;
    start_i = 1'b1; start_addr = ADDR_W'(a);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      es  = st_at(k, n, m, s);
      ns  = st_at(k + 1, n, m, s);
      act = early ? (ns != 1) : (es != 1);
      chk(dvalid == (es == 1), req, "dvalid", dvalid, es == 1);
      chk(wait_oe == 1'b1, "R1", "wait_oe in read", wait_oe, 1);
      chk(wait_o == (pol ? act : !act), (es == 2) ? "R8" : (k < n ? "R4" : "R5"),
          "wait_o", wait_o, pol ? act : !act);
      if (es == 1) begin
        d = k - n;
        j = d - ((s > 0 && d >= m + s) ? s : 0);
        chk(data_addr == ADDR_W'(exp_addr(a, j, wact, bl)), wact ? "R7" : "R6",
            "data_addr", data_addr, exp_addr(a, j, wact, bl));
      end
      @(negedge clk);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    #1;
    chk(wait_oe == 1'b0, "R1", "wait_oe with CE high", wait_oe, 0);
    chk(dvalid == 1'b0, "R10", "dvalid with CE high", dvalid, 0);
  endtask

  initial begin
    #(200_000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R11 / R1: reset state with bus active
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(wait_oe == 1'b0, "R11", "wait_oe in reset", wait_oe, 0);
    chk(dvalid == 1'b0, "R11", "dvalid in reset", dvalid, 0);
    rst_n = 1'b1;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk(dvalid == 1'b0, "R11", "dvalid after reset", dvalid, 0);
    chk(wait_oe == 1'b0, "R1", "wait_oe CE high", wait_oe, 0);

    // R1: OE high with CE low, and a write
    ce_n = 1'b0; #1;
    chk(wait_oe == 1'b0, "R1", "wait_oe OE high", wait_oe, 0);
    we_n = 1'b0; oe_n = 1'b1; #1;
    chk(wait_oe == 1'b0, "R1", "wait_oe write", wait_oe, 0);
    we_n = 1'b1;

    // R2 / R3: asynchronous read drives deasserted level for both polarities
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      sync_en = 1'b0; oe_n = 1'b0; wait_pol = p[0]; lat_cnt = 5'd4;
      start_i = 1'b1; start_addr = 16'h0010;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 8; k++) begin
        chk(wait_oe == 1'b1, "R2", "async wait_oe", wait_oe, 1);
        chk(wait_o == !p[0], "R3", "async deasserted level", wait_o, !p[0]);
        chk(dvalid == 1'b0, "R2", "async start ignored", dvalid, 0);
        @(negedge clk);
      end
    end
    ce_n = 1'b1; oe_n = 1'b1; sync_en = 1'b1;
    @(negedge clk);

    // R9: unsupported latency counts
    for (int i = 0; i < 3; i++) begin
      int nb;
      nb = (i == 0) ? 2 : ((i == 1) ? 17 : 0);
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; lat_cnt = LAT_W'(nb); wait_pol = 1'b1;
      start_i = 1'b1; start_addr = 16'h0003;
      @(negedge clk);
      start_i = 1'b0;
      chk(cfg_bad == 1'b1, "R9", "cfg_bad", cfg_bad, 1);
      for (int k = 0; k < 20; k++) begin
        chk(dvalid == 1'b0, "R9", "no burst on bad latency", dvalid, 0);
        chk(wait_o == 1'b0, "R9", "wait deasserted", wait_o, 0);
        @(negedge clk);
      end
      ce_n = 1'b1; oe_n = 1'b1;
    end
    lat_cnt = 5'd3; #1;
    chk(cfg_bad == 1'b0, "R9", "cfg_bad at 3", cfg_bad, 0);
    lat_cnt = 5'd16; #1;
    chk(cfg_bad == 1'b0, "R9", "cfg_bad at 16", cfg_bad, 0);

    // directed bursts
    burst(3, 16'h0100, 0, 3, 0, 0, 12, "R4");           // minimum latency
    burst(16, 16'h204F, 0, 3, 1, 1, 50, "R8");          // offset 15: 14 stalls
    burst(8, 16'h300A, 0, 2, 0, 1, 50, "R8");           // 6 stalls, second crossing clean
    burst(5, 16'h1236, 1, 0, 0, 0, 20, "R7");           // wrap in 4
    burst(10, 16'h4009, 1, 2, 1, 1, 40, "R7");          // wrap in 16, no stall
    burst(6, 16'h500C, 1, 3, 0, 0, 30, "R6");           // wrap bit with continuous
    burst(4, 16'hFFFE, 0, 3, 1, 0, 12, "R6");           // address rollover
    burst(12, 16'h6005, 1, 1, 0, 1, 30, "R7");          // wrap in 8

    // R10: OE high pauses output, CE high ends burst
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; lat_cnt = 5'd4; wrap_en = 1'b0; burst_len = 2'd3;
    wait_pol = 1'b0; wait_early = 1'b0; start_i = 1'b1; start_addr = 16'h0700;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    oe_n = 1'b1; #1;
    chk(dvalid == 1'b0, "R10", "dvalid with OE high", dvalid, 0);
    chk(wait_oe == 1'b0, "R10", "wait_oe with OE high", wait_oe, 0);
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(dvalid == 1'b0, "R10", "burst ended by CE", dvalid, 0);
      chk(wait_o == 1'b1, "R10", "idle wait deasserted", wait_o, 1);
    end
    ce_n = 1'b1; oe_n = 1'b1;

    // constrained random bursts
    for (int t = 0; t < 40; t++) begin
      int n, a, bl;
      bit wr, pol, early;
      n     = 3 + int'($urandom % 14);
      a     = int'($urandom & 32'hFFFF);
      bl    = int'($urandom % 4);
      wr    = 1'($urandom);
      pol   = 1'($urandom);
      early = 1'($urandom);
      burst(n, a, wr, bl, pol, early, n + 36, "R5");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule